// File: doc/BRIEF.md
# Private Interrupt Group Resolver and Software-Interrupt Gate

This block sits beside the per-processor interrupt state of an interrupt controller. For every private interrupt (the software-generated ones and the per-processor peripheral ones), it turns the stored group bit and group-modifier bit into an effective security group. Whether security is disabled changes how the two bits are read. The resulting per-interrupt group vector is brought out for the storage and arbitration logic around the block.

The block also checks each incoming software-generated interrupt request. A request is a one-cycle valid pulse carrying an interrupt number from 0 to 15, a requested group and a flag that marks a non-secure origin. In the same cycle the gate decides whether the request is accepted or dropped. It judges the requested group against the configured one and, for non-secure requests, against a 2-bit access level held per interrupt. An accepted request produces a one-hot pending-set strobe, and one cycle later a re-arbitration pulse.

A third, registered output reports for each group whether this processor may be picked as the target of a one-of-many interrupt. The processor must be awake, the group must be globally enabled, and the processor's own disable bit for that group must be clear. The pending storage and the priority arbitration live outside the block.

Top module: `sgi_group_gate`

## Requirements
- R1: With `sec_disable`=1, interrupt i has effective group 0 (code 0) when `grp_bits[i]`=0 and non-secure group 1 (code 2) when `grp_bits[i]`=1, whatever `mod_bits[i]` holds. Group codes are 0 = group 0, 1 = secure group 1, 2 = non-secure group 1. The code of interrupt i appears on `eff_grp[2i+1:2i]`.
- R2: With `sec_disable`=0, the pair (`mod_bits[i]`,`grp_bits[i]`) maps 00 to code 0, 01 to code 2, 10 to code 1 and 11 to code 2. Code 3 never appears.
- R3: A request for secure group 1 (`req_grp`=1) aimed at an interrupt whose effective group is 0 is handled as a group 0 request, so it is accepted unless R5 drops it.
- R4: A group 0 request (`req_grp`=0) aimed at an interrupt whose effective group is not 0 is dropped.
- R5: When `req_ns`=1 and `sec_disable`=0, a request is dropped if its target has effective group 0 and an access level below 1, or effective group 1 (secure group 1) and an access level below 2. The access level of interrupt i is `acl_bits[2i+1:2i]`. Targets in non-secure group 1, and all requests while `sec_disable`=1, are not limited by the access level.
- R6: A request whose `req_grp` is 3 (reserved) is always dropped.
- R7: In a cycle with `req_valid`=1, exactly one of `req_accept` and `req_drop` is high in that same cycle. On accept, `set_pend` has only bit `req_id` set. With `req_valid`=0, `req_accept`, `req_drop` and `set_pend` are all zero.
- R8: `rearb` is high in exactly the cycle after each accepted request and low otherwise.
- R9: `tgt_ok[g]` for group code g (0..2) is registered with one cycle of latency. It is 1 only when `pe_asleep`=0, `grp_en[g]`=1 and `grp_dis[g]`=0.
- R10: While `rst` is high, `rearb` and `tgt_ok` are forced to zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_disable | input | 1 | Security disabled (single security state) |
| grp_bits | input | NUM_PRIV | Group bit per private interrupt |
| mod_bits | input | NUM_PRIV | Group-modifier bit per private interrupt |
| acl_bits | input | 2*NUM_SGI | Non-secure access level per software interrupt |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_id | input | log2(NUM_SGI) | Target software interrupt number |
| req_grp | input | 2 | Requested group code |
| req_ns | input | 1 | Request comes from the non-secure state |
| pe_asleep | input | 1 | Processor is in its low-power state |
| grp_en | input | 3 | Global enable per group code |
| grp_dis | input | 3 | Processor-local disable per group code |
| eff_grp | output | 2*NUM_PRIV | Effective group code per private interrupt |
| req_accept | output | 1 | Request accepted (same cycle) |
| req_drop | output | 1 | Request dropped (same cycle) |
| set_pend | output | NUM_SGI | One-hot pending-set strobe |
| rearb | output | 1 | Re-arbitration pulse, one cycle after accept |
| tgt_ok | output | 3 | Processor may be chosen as one-of-many target, per group |

## Verification
The assertions assume that `req_valid` is a clean synchronous strobe, and that `req_id`, `req_grp` and `req_ns` are stable whenever it is high. Configuration inputs may change in any cycle, because the gate and the mapping are combinational. The stimulus changes every input only on the falling clock edge and holds request fields for the full valid cycle. It sweeps every interrupt number, every requested group code and both origins under both security settings, with mixed group and access-level configurations. The target-eligibility inputs are swept exhaustively.

// File: rtl/sgi_gate_pkg.sv
package sgi_gate_pkg;

  typedef enum logic [1:0] {
    GRP_0   = 2'd0,
    GRP_1S  = 2'd1,
    GRP_1NS = 2'd2,
    GRP_RSV = 2'd3
  } grp_e;

  localparam int NUM_GRP = 3;

  function automatic grp_e map_grp(input logic sd, input logic m, input logic g);
    grp_e r;
    if (sd) begin
      r = g ? GRP_1NS : GRP_0;
    end else begin
      case ({m, g})
        2'b00:   r = GRP_0;
        2'b10:   r = GRP_1S;
        default: r = GRP_1NS;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/grp_resolve.sv
module grp_resolve #(
  parameter int N = 32
) (
  input  logic           sd,
  input  logic [N-1:0]   grp_bits,
  input  logic [N-1:0]   mod_bits,
  output logic [2*N-1:0] eff_flat
);
  import sgi_gate_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_int
    assign eff_flat[2*i +: 2] = map_grp(sd, mod_bits[i], grp_bits[i]);
  end

endmodule

// File: rtl/sgi_filter.sv
module sgi_filter #(
  parameter int NUM_SGI = 16,
  localparam int IDW = $clog2(NUM_SGI)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sd,
  input  logic               req_valid,
  input  logic [IDW-1:0]     req_id,
  input  logic [1:0]         req_grp,
  input  logic               req_ns,
  input  logic [1:0]         cfg_grp,
  input  logic [1:0]         acl,
  output logic               accept,
  output logic               drop,
  output logic [NUM_SGI-1:0] set_pend,
  output logic               rearb
);
  import sgi_gate_pkg::*;

  grp_e cfg;
  grp_e rq;
  logic ok;

  assign cfg = grp_e'(cfg_grp);

  always_comb begin
    rq = grp_e'(req_grp);
    // secure group 1 request on a group 0 interrupt is promoted to group 0
    if (rq == GRP_1S && cfg == GRP_0) rq = GRP_0;
    ok = (rq != GRP_RSV);
    if (rq == GRP_0 && cfg != GRP_0) ok = 1'b0;
    if (req_ns && !sd) begin
      if (cfg == GRP_0  && acl < 2'd1) ok = 1'b0;
      if (cfg == GRP_1S && acl < 2'd2) ok = 1'b0;
    end
  end

  assign accept = req_valid & ok;
  assign drop   = req_valid & ~ok;

  always_comb begin
    set_pend = '0;
    if (accept) set_pend[req_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rearb <= 1'b0;
    else     rearb <= accept;
  end

endmodule

// File: rtl/target_elig.sv
module target_elig #(
  parameter int NG = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          asleep,
  input  logic [NG-1:0] en,
  input  logic [NG-1:0] dis,
  output logic [NG-1:0] ok
);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) ok[g] <= 1'b0;
      else     ok[g] <= ~asleep & en[g] & ~dis[g];
    end
  end

endmodule

// File: rtl/sgi_group_gate.sv
module sgi_group_gate #(
  parameter int NUM_SGI  = 16,
  parameter int NUM_PRIV = 32,
  localparam int IDW = $clog2(NUM_SGI),
  localparam int NG  = sgi_gate_pkg::NUM_GRP
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sec_disable,
  input  logic [NUM_PRIV-1:0]   grp_bits,
  input  logic [NUM_PRIV-1:0]   mod_bits,
  input  logic [2*NUM_SGI-1:0]  acl_bits,
  input  logic                  req_valid,
  input  logic [IDW-1:0]        req_id,
  input  logic [1:0]            req_grp,
  input  logic                  req_ns,
  input  logic                  pe_asleep,
  input  logic [NG-1:0]         grp_en,
  input  logic [NG-1:0]         grp_dis,
  output logic [2*NUM_PRIV-1:0] eff_grp,
  output logic                  req_accept,
  output logic                  req_drop,
  output logic [NUM_SGI-1:0]    set_pend,
  output logic                  rearb,
  output logic [NG-1:0]         tgt_ok
);

  logic [1:0] sel_grp;
  logic [1:0] sel_acl;

  grp_resolve #(.N(NUM_PRIV)) u_res (
    .sd       (sec_disable),
    .grp_bits (grp_bits),
    .mod_bits (mod_bits),
    .eff_flat (eff_grp)
  );

  assign sel_grp = eff_grp[{req_id, 1'b0} +: 2];
  assign sel_acl = acl_bits[{req_id, 1'b0} +: 2];

  sgi_filter #(.NUM_SGI(NUM_SGI)) u_flt (
    .clk       (clk),
    .rst       (rst),
    .sd        (sec_disable),
    .req_valid (req_valid),
    .req_id    (req_id),
    .req_grp   (req_grp),
    .req_ns    (req_ns),
    .cfg_grp   (sel_grp),
    .acl       (sel_acl),
    .accept    (req_accept),
    .drop      (req_drop),
    .set_pend  (set_pend),
    .rearb     (rearb)
  );

  target_elig #(.NG(NG)) u_tgt (
    .clk    (clk),
    .rst    (rst),
    .asleep (pe_asleep),
    .en     (grp_en),
    .dis    (grp_dis),
    .ok     (tgt_ok)
  );

endmodule

// File: rtl/sgi_group_gate_chk.sv
module sgi_group_gate_chk #(
  parameter int NUM_SGI  = 16,
  parameter int NUM_PRIV = 32,
  localparam int IDW = $clog2(NUM_SGI),
  localparam int NG  = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sec_disable,
  input logic [2*NUM_SGI-1:0]  acl_bits,
  input logic                  req_valid,
  input logic [IDW-1:0]        req_id,
  input logic [1:0]            req_grp,
  input logic                  req_ns,
  input logic                  pe_asleep,
  input logic [2*NUM_PRIV-1:0] eff_grp,
  input logic                  req_accept,
  input logic                  req_drop,
  input logic [NUM_SGI-1:0]    set_pend,
  input logic                  rearb,
  input logic [NG-1:0]         tgt_ok
);

  logic any_g1s, any_rsv;
  logic [1:0] tgt_grp;

  always_comb begin
    any_g1s = 1'b0;
    any_rsv = 1'b0;
    for (int i = 0; i < NUM_PRIV; i++) begin
      if (eff_grp[2*i +: 2] == 2'd1) any_g1s = 1'b1;
      if (eff_grp[2*i +: 2] == 2'd3) any_rsv = 1'b1;
    end
  end

  assign tgt_grp = eff_grp[{req_id, 1'b0} +: 2];

  assert_sd_map_R1: assert property (@(posedge clk) disable iff (rst)
    sec_disable |-> !any_g1s);
  assert_no_rsv_R2: assert property (@(posedge clk) disable iff (rst)
    !any_rsv);
  assert_g0_req_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_grp == 2'd0 && req_accept) |-> tgt_grp == 2'd0);
  assert_ns_acl_R5: assert property (@(posedge clk) disable iff (rst)
    (req_accept && req_ns && !sec_disable && tgt_grp == 2'd1) |->
      acl_bits[{req_id, 1'b0} +: 2] >= 2'd2);
  assert_rsv_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_grp == 2'd3) |-> req_drop);
  assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_accept ^ req_drop));
  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!req_accept && !req_drop && set_pend == '0));
  assert_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    req_accept |-> ($countones(set_pend) == 1 && set_pend[req_id]));
  assert_rearb_R8: assert property (@(posedge clk) disable iff (rst)
    req_accept |=> rearb);
  assert_rearb_src_R8: assert property (@(posedge clk) disable iff (rst)
    rearb |-> $past(req_accept));
  assert_sleep_R9: assert property (@(posedge clk) disable iff (rst)
    pe_asleep |=> tgt_ok == '0);

endmodule

bind sgi_group_gate sgi_group_gate_chk #(.NUM_SGI(NUM_SGI), .NUM_PRIV(NUM_PRIV)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sec_disable (sec_disable),
  .acl_bits    (acl_bits),
  .req_valid   (req_valid),
  .req_id      (req_id),
  .req_grp     (req_grp),
  .req_ns      (req_ns),
  .pe_asleep   (pe_asleep),
  .eff_grp     (eff_grp),
  .req_accept  (req_accept),
  .req_drop    (req_drop),
  .set_pend    (set_pend),
  .rearb       (rearb),
  .tgt_ok      (tgt_ok)
);

// File: tb/sgi_group_gate_tb.sv
`timescale 1ns/1ps
module sgi_group_gate_tb;

  localparam int NS = 16;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sec_disable = 1'b0;
  logic [NP-1:0] grp_bits = '0;
  logic [NP-1:0] mod_bits = '0;
  logic [2*NS-1:0] acl_bits = '0;
  logic          req_valid = 1'b0;
  logic [3:0]    req_id = '0;
  logic [1:0]    req_grp = '0;
  logic          req_ns = 1'b0;
  logic          pe_asleep = 1'b0;
  logic [2:0]    grp_en = '0;
  logic [2:0]    grp_dis = '0;
  logic [2*NP-1:0] eff_grp;
  logic          req_accept, req_drop, rearb;
  logic [NS-1:0] set_pend;
  logic [2:0]    tgt_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          acc;
    logic [15:0] sp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  sgi_group_gate u_dut (.*);

  task automatic check(input bit cond, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] m_grp(bit sd, bit m, bit g);
    if (sd) return g ? 2'd2 : 2'd0;
    if (!m) return g ? 2'd2 : 2'd0;
    return g ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [2*NP-1:0] m_vec(bit sd, logic [NP-1:0] gb, logic [NP-1:0] mb);
    logic [2*NP-1:0] v;
    for (int i = 0; i < NP; i++) v[2*i +: 2] = m_grp(sd, mb[i], gb[i]);
    return v;
  endfunction

  // monitor: compares gate results against the scoreboard (R7)
  always @(posedge clk) begin
    if (!rst && !done) begin
      if (req_valid) begin
        if (sb.size() == 0) begin
          check(0, "R7", "unexpected request", 0, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(req_accept == e.acc && req_drop == !e.acc, e.tag, "accept",
                req_accept, e.acc);
          check(set_pend == (e.acc ? e.sp : 16'h0), "R7", "set_pend",
                set_pend, e.acc ? e.sp : 16'h0);
        end
      end else begin
        check(!req_accept && !req_drop && set_pend == '0, "R7", "idle",
              {req_accept, req_drop, set_pend}, 0);
      end
    end
  end

  task automatic send(input int id, input logic [1:0] rg, input bit ns);
    exp_t e;
    logic [1:0] cfg, eg;
    bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_id = 4'(id); req_grp = rg; req_ns = ns;
    cfg = m_grp(sec_disable, mod_bits[id], grp_bits[id]);
    eg = rg;
    e.tag = "R7";
    ok = 1;
    if (rg == 2'd3) begin ok = 0; e.tag = "R6"; end
    else begin
      if (eg == 2'd1 && cfg == 2'd0) begin eg = 2'd0; e.tag = "R3"; end
      if (eg == 2'd0 && cfg != 2'd0) begin ok = 0; e.tag = "R4"; end
      if (ok && ns && !sec_disable) begin
        if (cfg == 2'd0 && acl_bits[2*id +: 2] < 2'd1) begin ok = 0; e.tag = "R5"; end
        if (cfg == 2'd1 && acl_bits[2*id +: 2] < 2'd2) begin ok = 0; e.tag = "R5"; end
        if (ok) e.tag = "R5";
      end
    end
    e.acc = ok;
    e.sp = 16'h1 << id;
    sb.push_back(e);
    @(negedge clk);
    check(rearb == ok, "R8", "rearb after request", rearb, ok);
    req_valid = 1'b0;
    @(negedge clk);
    check(rearb == 1'b0, "R8", "rearb clears", rearb, 0);
  endtask

  task automatic map_case(input bit sd, input logic [NP-1:0] gb, input logic [NP-1:0] mb,
                          input string tag);
    @(negedge clk);
    sec_disable = sd; grp_bits = gb; mod_bits = mb;
    #1;
    check(eff_grp == m_vec(sd, gb, mb), tag, "eff_grp", eff_grp, m_vec(sd, gb, mb));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset: drive values that would set registered outputs if reset were ignored
    grp_en = 3'b111; grp_dis = 3'b000; pe_asleep = 1'b0;
    req_valid = 1'b1; req_grp = 2'd2; req_id = 4'd1; grp_bits = '1;
    repeat (3) @(negedge clk);
    check(tgt_ok == 3'b000, "R10", "tgt_ok in reset", tgt_ok, 0);
    check(rearb == 1'b0, "R10", "rearb in reset", rearb, 0);
    req_valid = 1'b0;
    rst = 1'b0;

    // R1 / R2 mapping
    map_case(1, 32'hA5A5_F00F, 32'h0FF0_3C3C, "R1");
    map_case(1, 32'h1234_5678, 32'hFFFF_FFFF, "R1");
    map_case(0, 32'hA5A5_F00F, 32'h0FF0_3C3C, "R2");
    map_case(0, 32'h0000_0000, 32'hFFFF_FFFF, "R2");
    map_case(0, 32'h5555_5555, 32'h3333_3333, "R2");

    // config: per SGI (mod,grp) cycles 00,01,10,11; access level = id[3:2]
    for (int i = 0; i < NS; i++) begin
      grp_bits[i] = i[0];
      mod_bits[i] = i[1];
      acl_bits[2*i +: 2] = 2'(i >> 2);
    end

    // directed cases
    sec_disable = 0;
    send(0, 2'd1, 0);   // R3: G1S on G0, secure -> accepted
    send(4, 2'd1, 1);   // R3 with R5: acl 1 -> accepted
    send(0, 2'd1, 1);   // R5: acl 0 on G0 -> dropped
    send(1, 2'd0, 0);   // R4: G0 on G1NS -> dropped
    send(2, 2'd0, 0);   // R4: G0 on G1S -> dropped
    send(6, 2'd1, 1);   // R5: G1S, acl 1 -> dropped
    send(10, 2'd1, 1);  // R5: G1S, acl 2 -> accepted
    send(1, 2'd2, 1);   // R5: G1NS target unaffected
    send(5, 2'd3, 0);   // R6: reserved
    sec_disable = 1;
    send(0, 2'd1, 1);   // R5: access level ignored when security disabled

    // sweeps under both security settings
    for (int s = 0; s < 2; s++) begin
      sec_disable = s[0];
      for (int i = 0; i < NS; i++)
        for (int g = 0; g < 4; g++)
          for (int n = 0; n < 2; n++)
            send(i, 2'(g), n[0]);
    end

    // R9: exhaustive target eligibility
    for (int a = 0; a < 2; a++)
      for (int en = 0; en < 8; en++)
        for (int d = 0; d < 8; d++) begin
          logic [2:0] ex;
          @(negedge clk);
          pe_asleep = a[0]; grp_en = 3'(en); grp_dis = 3'(d);
          ex = a[0] ? 3'b000 : (3'(en) & ~3'(d));
          @(negedge clk);
          check(tgt_ok == ex, "R9", "tgt_ok", tgt_ok, ex);
        end

    // R10: reset clears registered outputs mid-run
    @(negedge clk);
    pe_asleep = 0; grp_en = 3'b111; grp_dis = 3'b000;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(tgt_ok == 3'b000, "R10", "tgt_ok after reset", tgt_ok, 0);
    rst = 1'b0;

    check(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule